// File: doc/BRIEF.md
# Single-Buffer Peripheral DMA Channel

This block moves one contiguous buffer between a peripheral and memory. Software loads a configuration word, a start address and a byte count through a 32-bit register port, then writes 1 to a run register. Each data request from the peripheral starts one 32-bit beat on a simple memory master port. A beat lasts a programmable number of wait cycles plus one.

The direction comes from one configuration flag. In transmit mode the channel reads memory and hands the word to the peripheral. In receive mode it writes the peripheral's word into memory.

While the transfer runs, software can read a live address and a live remaining-byte count. Completion shows up in three ways: the live address equals start address plus byte count, the remaining count reads zero, and an end flag is raised. The end flag can be enabled as an interrupt and is cleared by writing 1 to it. A second channel exists only as a pair of interrupt bits. Its end event arrives on an input pin.

Top module: `sdma_channel`

## Requirements
- R1: After synchronous reset every register reads 0, and `irq`, `mem_valid` and `per_ack` are low.
- R2: Register offsets are settings 0x00, start address 0x10, byte count 0x18 (26 bits), live address 0x20, live count 0x28, run 0x30 (bit 0), interrupt enable 0x40, end flags 0x44 and flag clear 0x48. In the settings word, bit 12 selects transmit mode, bit 8 is a stored receive-end flag, and bits 5:4 hold the wait count. All other settings bits read 0, and any other offset reads 0. Read data appears one cycle after `reg_re`.
- R3: While run reads 1, writes to settings, start address and byte count are ignored.
- R4: While running and idle, a high `per_req` starts a beat. `mem_valid` then stays high for wait+1 cycles with `mem_addr` equal to the live address. `per_ack` pulses for exactly one cycle right after `mem_valid` falls.
- R5: Each beat advances the live address by `step` and reduces the live count by `step`, where `step` = min(4, remaining).
- R6: When the live count reaches 0, run clears by itself and end flag bit 0 sets. At that point the live address equals start address plus byte count.
- R7: Writing run=1 with a byte count of 0 sets end flag bit 0 on the next edge. No beat is issued and run stays 0.
- R8: `irq` is high while (end flags AND enable) is nonzero. Writing 1s to flag clear clears the matching flags. A pulse on `ch1_end` sets flag bit 1.
- R9: Writing run=0 stops the channel and drops any beat in flight. The end flag is not set, and the live address and count keep their values.
- R10: In transmit mode `mem_write` is low, and `per_wdata` takes `mem_rdata` from the last beat cycle. In receive mode `mem_write` is high, and `mem_wdata` carries `per_rdata` captured when the beat starts.
- R11: A flag set event and a clear of the same bit in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| per_req | input | 1 | Peripheral data request |
| per_rdata | input | 32 | Word from the peripheral (receive mode) |
| per_ack | output | 1 | One-cycle beat completion to the peripheral |
| per_wdata | output | 32 | Word to the peripheral (transmit mode) |
| mem_valid | output | 1 | Memory access in progress |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| ch1_end | input | 1 | End event of the second channel |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
A wrong live address or count shows up at `mem_addr` on the next beat. It also shows up in the readback of the live registers as soon as the transfer stops. An error in the completion logic shows within one cycle of the last `per_ack`: `irq` either fails to rise or rises early, and run stays set or clears too soon. Errors in wait counting change the length of every `mem_valid` burst, so the first beat of a run exposes them.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [7:0] OFS_CFG   = 8'h00;
  localparam logic [7:0] OFS_BASE  = 8'h10;
  localparam logic [7:0] OFS_BCNT  = 8'h18;
  localparam logic [7:0] OFS_CUR   = 8'h20;
  localparam logic [7:0] OFS_CCNT  = 8'h28;
  localparam logic [7:0] OFS_RUN   = 8'h30;
  localparam logic [7:0] OFS_IEN   = 8'h40;
  localparam logic [7:0] OFS_IST   = 8'h44;
  localparam logic [7:0] OFS_ICLR  = 8'h48;

  localparam int TX_BIT    = 12;
  localparam int RXEND_BIT = 8;
  localparam int WAIT_LSB  = 4;
  localparam int WAIT_W    = 2;

  typedef struct packed {
    logic              tx_mode;
    logic              rx_end;
    logic [WAIT_W-1:0] wait_cnt;
  } cfg_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 26,
  parameter int NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            busy,
  input  logic            done,
  input  logic            ch1_end,
  input  logic [AW-1:0]   cur,
  input  logic [CW-1:0]   cnt,
  output cfg_t            cfg,
  output logic [AW-1:0]   base,
  output logic [CW-1:0]   bcnt,
  output logic            run_wr,
  output logic            run_wval,
  output logic            irq
);
  cfg_t            cfg_q;
  logic [AW-1:0]   base_q;
  logic [CW-1:0]   bcnt_q;
  logic [NIRQ-1:0] ien_q, ist_q, ien_d, ist_d, set_v, clr_v;
  logic [31:0]     rd_v;
  logic            irq_q;
  logic [31:0]     rdata_q;

  assign run_wr   = reg_we && (reg_addr == OFS_RUN);
  assign run_wval = reg_wdata[0];

  always_comb begin
    set_v    = '0;
    set_v[0] = done;
    set_v[1] = ch1_end;
    clr_v    = (reg_we && reg_addr == OFS_ICLR) ? reg_wdata[NIRQ-1:0] : '0;
    ist_d    = (ist_q & ~clr_v) | set_v;
    ien_d    = (reg_we && reg_addr == OFS_IEN) ? reg_wdata[NIRQ-1:0] : ien_q;
  end

  always_comb begin
    rd_v = '0;
    case (reg_addr)
      OFS_CFG: begin
        rd_v[TX_BIT]                     = cfg_q.tx_mode;
        rd_v[RXEND_BIT]                  = cfg_q.rx_end;
        rd_v[WAIT_LSB +: WAIT_W]         = cfg_q.wait_cnt;
      end
      OFS_BASE: rd_v[AW-1:0]   = base_q;
      OFS_BCNT: rd_v[CW-1:0]   = bcnt_q;
      OFS_CUR:  rd_v[AW-1:0]   = cur;
      OFS_CCNT: rd_v[CW-1:0]   = cnt;
      OFS_RUN:  rd_v[0]        = busy;
      OFS_IEN:  rd_v[NIRQ-1:0] = ien_q;
      OFS_IST:  rd_v[NIRQ-1:0] = ist_q;
      default:  rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      base_q  <= '0;
      bcnt_q  <= '0;
      ien_q   <= '0;
      ist_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_we && !busy) begin
        case (reg_addr)
          OFS_CFG: begin
            cfg_q.tx_mode  <= reg_wdata[TX_BIT];
            cfg_q.rx_end   <= reg_wdata[RXEND_BIT];
            cfg_q.wait_cnt <= reg_wdata[WAIT_LSB +: WAIT_W];
          end
          OFS_BASE: base_q <= reg_wdata[AW-1:0];
          OFS_BCNT: bcnt_q <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      ien_q <= ien_d;
      ist_q <= ist_d;
      irq_q <= |(ist_d & ien_d);
      if (reg_re) rdata_q <= rd_v;
    end
  end

  assign cfg       = cfg_q;
  assign base      = base_q;
  assign bcnt      = bcnt_q;
  assign irq       = irq_q;
  assign reg_rdata = rdata_q;

  // R3: programming registers frozen while the channel runs
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(base_q) && $stable(bcnt_q) && $stable(cfg_q)));

  // R8: clearing a flag with no new event removes it
  p_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == OFS_ICLR && reg_wdata[0] && !done) |=> !ist_q[0]);

  // R11: an end event always lands in the flag
  p_set_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> ist_q[0]);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_wr,
  input  logic              run_wval,
  input  logic [AW-1:0]     base,
  input  logic [CW-1:0]     bcnt,
  input  logic              tx_mode,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              per_req,
  input  logic [DW-1:0]     per_rdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              per_ack,
  output logic [DW-1:0]     per_wdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     cur,
  output logic [CW-1:0]     cnt
);
  localparam int BPW = DW / 8;
  localparam logic [CW-1:0] WORD_BYTES = CW'(BPW);

  logic              run_q, done_q, ack_q, valid_q, write_q;
  logic [AW-1:0]     cur_q, addr_q;
  logic [CW-1:0]     cnt_q, step;
  logic [WAIT_W-1:0] wcnt_q;
  logic [DW-1:0]     pw_q, mw_q;
  logic              last;

  assign step = (cnt_q < WORD_BYTES) ? cnt_q : WORD_BYTES;
  assign last = (cnt_q <= WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      write_q <= 1'b0;
      cur_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      pw_q    <= '0;
      mw_q    <= '0;
    end else begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      if (run_wr) begin
        if (run_wval) begin
          if (!run_q) begin
            if (bcnt == '0) begin
              done_q <= 1'b1;
            end else begin
              run_q <= 1'b1;
              cur_q <= base;
              cnt_q <= bcnt;
            end
          end
        end else begin
          run_q   <= 1'b0;
          valid_q <= 1'b0;
        end
      end else if (run_q) begin
        if (!valid_q) begin
          if (per_req) begin
            valid_q <= 1'b1;
            wcnt_q  <= wait_cnt;
            addr_q  <= cur_q;
            write_q <= !tx_mode;
            mw_q    <= per_rdata;
          end
        end else if (wcnt_q != '0) begin
          wcnt_q <= wcnt_q - 1'b1;
        end else begin
          valid_q <= 1'b0;
          ack_q   <= 1'b1;
          cur_q   <= cur_q + AW'(step);
          cnt_q   <= cnt_q - step;
          if (tx_mode) pw_q <= mem_rdata;
          if (last) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy      = run_q;
  assign done      = done_q;
  assign per_ack   = ack_q;
  assign per_wdata = pw_q;
  assign mem_valid = valid_q;
  assign mem_write = write_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = mw_q;
  assign cur       = cur_q;
  assign cnt       = cnt_q;

  // R4: memory activity only while the channel runs
  p_valid_r4: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> run_q);

  // R4: acknowledge follows the end of a memory access
  p_ack_r4: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (!valid_q && $past(valid_q)));

  // R5: live count never grows during a run
  p_cnt_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> (cnt_q <= $past(cnt_q)));

  // R6: bytes moved agree between address and count
  p_sum_r6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ((cur_q - base) == AW'(bcnt - cnt_q)));

  // R6: completion leaves the channel stopped
  p_done_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !run_q);
endmodule

// File: rtl/sdma_channel.sv
module sdma_channel
  import sdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          per_req,
  input  logic [DW-1:0] per_rdata,
  output logic          per_ack,
  output logic [DW-1:0] per_wdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ch1_end,
  output logic          irq
);
  cfg_t          cfg;
  logic [AW-1:0] base, cur;
  logic [CW-1:0] bcnt, cnt;
  logic          busy, done, run_wr, run_wval;

  sdma_regs #(.AW(AW), .CW(CW), .NIRQ(2)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .ch1_end(ch1_end), .cur(cur), .cnt(cnt),
    .cfg(cfg), .base(base), .bcnt(bcnt), .run_wr(run_wr),
    .run_wval(run_wval), .irq(irq)
  );

  sdma_engine #(.AW(AW), .CW(CW), .DW(DW)) u_engine (
    .clk(clk), .rst(rst), .run_wr(run_wr), .run_wval(run_wval),
    .base(base), .bcnt(bcnt), .tx_mode(cfg.tx_mode), .wait_cnt(cfg.wait_cnt),
    .per_req(per_req), .per_rdata(per_rdata), .mem_rdata(mem_rdata),
    .per_ack(per_ack), .per_wdata(per_wdata), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .cur(cur), .cnt(cnt)
  );

  // R8: interrupt never pulses without a cause latched one cycle earlier
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(done) || $past(ch1_end) || $past(reg_we)));
endmodule

// File: tb/sdma_channel_test.sv
`timescale 1ns/1ps
module sdma_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        per_req = 1'b0, per_ack;
  logic [31:0] per_rdata = '0, per_wdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        ch1_end = 1'b0, irq;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdma_channel uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .per_req(per_req), .per_rdata(per_rdata), .per_ack(per_ack),
    .per_wdata(per_wdata), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ch1_end(ch1_end), .irq(irq)
  );

  // base, count, wait, tx
  localparam int NV = 5;
  localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h40, 32'h5000};
  localparam logic [31:0] V_CNT  [NV] = '{32'd16, 32'd7, 32'd4, 32'd1, 32'd13};
  localparam logic [1:0]  V_WAIT [NV] = '{2'd0, 2'd1, 2'd3, 2'd2, 2'd0};
  localparam logic        V_TX   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !mem_valid && !per_ack, "R1 outputs", {29'b0, irq, mem_valid, per_ack}, 32'h0);
    rdchk(8'h00, 32'h0, "R1 settings");
    rdchk(8'h28, 32'h0, "R1 live count");
    rdchk(8'h44, 32'h0, "R1 flags");
    // R2 field layout and unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);
    rdchk(8'h00, 32'h0000_1130, "R2 settings mask");
    wr(8'h18, 32'hFFFF_FFFF);
    rdchk(8'h18, 32'h03FF_FFFF, "R2 count width");
    rdchk(8'h50, 32'h0, "R2 unmapped");
    wr(8'h40, 32'h1);

    // table walk: R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      int beats, mv, guard;
      logic [31:0] nb;
      wr(8'h00, {19'b0, V_TX[i], 3'b0, 1'b0, 2'b0, V_WAIT[i], 4'b0});
      wr(8'h10, V_BASE[i]);
      wr(8'h18, V_CNT[i]);
      per_rdata = 32'h1234_0000 + i;
      mem_rdata = 32'hA5A5_0000 + i;
      per_req = 1'b1;
      wr(8'h30, 32'h1);
      beats = 0; mv = 0; guard = 0;
      nb = (V_CNT[i] + 3) / 4;
      while (!irq && guard < 300) begin
        if (mem_valid) begin
          if (mv == beats * (V_WAIT[i] + 1))
            chk(mem_addr == V_BASE[i] + 4 * beats, "R4 beat address", mem_addr, V_BASE[i] + 4 * beats);
          mv++;
          if (mv == 1) begin
            chk(mem_write == !V_TX[i], "R10 direction", {31'b0, mem_write}, {31'b0, !V_TX[i]});
            if (!V_TX[i]) chk(mem_wdata == per_rdata, "R10 receive data", mem_wdata, per_rdata);
          end
        end
        if (per_ack) begin
          beats++;
          if (V_TX[i] && beats == 1) chk(per_wdata == mem_rdata, "R10 transmit data", per_wdata, mem_rdata);
        end
        guard++;
        @(negedge clk);
      end
      per_req = 1'b0;
      chk(beats == nb, "R5 beat count", beats, nb);
      chk(mv == nb * (V_WAIT[i] + 1), "R4 valid cycles", mv, nb * (V_WAIT[i] + 1));
      rdchk(8'h20, V_BASE[i] + V_CNT[i], "R6 live address");
      rdchk(8'h28, 32'h0, "R6 live count");
      rdchk(8'h30, 32'h0, "R6 run cleared");
      rdchk(8'h44, 32'h1, "R6 end flag");
      wr(8'h48, 32'h1);
      chk(!irq, "R8 irq after clear", {31'b0, irq}, 32'h0);
    end

    // R7 zero count
    wr(8'h18, 32'h0);
    per_req = 1'b1;
    wr(8'h30, 32'h1);
    d = 0;
    for (int k = 0; k < 5; k++) begin
      if (mem_valid) d++;
      @(negedge clk);
    end
    per_req = 1'b0;
    chk(d == 0, "R7 no beats", d, 32'h0);
    chk(irq, "R7 irq", {31'b0, irq}, 32'h1);
    rdchk(8'h30, 32'h0, "R7 run stays 0");
    rdchk(8'h44, 32'h1, "R7 flag");
    wr(8'h48, 32'h1);

    // R3 and R9
    wr(8'h00, 32'h30);
    wr(8'h10, 32'h8000);
    wr(8'h18, 32'd40);
    wr(8'h30, 32'h1);
    wr(8'h10, 32'h9000);
    wr(8'h18, 32'd8);
    rdchk(8'h10, 32'h8000, "R3 base ignored");
    rdchk(8'h18, 32'd40, "R3 count ignored");
    rdchk(8'h30, 32'h1, "R9 running");
    @(negedge clk);
    per_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(mem_valid, "R9 beat in flight", {31'b0, mem_valid}, 32'h1);
    per_req = 1'b0;
    wr(8'h30, 32'h0);
    chk(!mem_valid, "R9 beat dropped", {31'b0, mem_valid}, 32'h0);
    rdchk(8'h30, 32'h0, "R9 run off");
    rdchk(8'h20, 32'h8000, "R9 address kept");
    rdchk(8'h28, 32'd40, "R9 count kept");
    rdchk(8'h44, 32'h0, "R9 no flag");

    // R8 second channel bits, R11 set wins
    @(negedge clk); ch1_end = 1'b1;
    @(negedge clk); ch1_end = 1'b0;
    chk(!irq, "R8 masked", {31'b0, irq}, 32'h0);
    rdchk(8'h44, 32'h2, "R8 ch1 flag");
    wr(8'h40, 32'h3);
    chk(irq, "R8 enabled", {31'b0, irq}, 32'h1);
    @(negedge clk);
    ch1_end = 1'b1; reg_we = 1'b1; reg_addr = 8'h48; reg_wdata = 32'h2;
    @(negedge clk);
    ch1_end = 1'b0; reg_we = 1'b0;
    rdchk(8'h44, 32'h2, "R11 set wins");
    wr(8'h48, 32'h2);
    chk(!irq, "R8 cleared", {31'b0, irq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule